// File: doc/BRIEF.md
# Nibble-Assembled Double-Buffered Converter Input Stage

This block sits between a 4-bit data bus and the switch drivers of a 12-bit digital-to-analog converter. A full word arrives as three nibbles. Each nibble is steered into its own 4-bit holding latch by an active-low select, and the select only takes effect while a shared active-low write strobe is also low. The completed word is then copied into a 12-bit output register by a separate active-low load signal, which is also qualified by the write strobe.

Because of this two-rank arrangement, the converter never sees a half-built word. The output code changes only when the output register is opened. Every storage element is a level-sensitive latch. While a rank is enabled it is transparent, and it keeps whatever value was on its input at the moment its enable dropped. If all controls are held low together, the bus runs straight through to the output, and the same nibble appears in all three positions. An active-low asynchronous reset clears every rank.

Top module: `nib_dac_front`

## Requirements
- R1: While `rst_n` is 0, all three nibble latches and the output register read zero, whatever the other inputs do. After reset is released, a load pulse gives `code` = 0x000.
- R2: Nibble latch i is transparent while both `sel_n[i]` and `wr_n` are 0. `sel_n[2]` feeds `code[11:8]`, `sel_n[1]` feeds `code[7:4]`, and `sel_n[0]` feeds `code[3:0]`. The latches can be written in any order.
- R3: A nibble latch keeps the bus value present when its enable ends. The enable can end by its select rising or by `wr_n` rising. Later bus changes are ignored until both signals are low again.
- R4: The output register is transparent while both `ld_n` and `wr_n` are 0. It then equals the concatenated nibble latches. Once either signal is 1, it holds.
- R5: With `ld_n` at 1, writing any nibble latch leaves `code` unchanged.
- R6: While `wr_n` is 1, no latch changes, whatever `sel_n`, `ld_n` and the bus do.
- R7: With `wr_n`, every `sel_n` bit and `ld_n` all at 0, `code` follows the bus with the bus nibble in all three positions. It keeps the last such value after `wr_n` rises.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rst_n | input | 1 | Asynchronous active-low clear of all ranks |
| wr_n | input | 1 | Shared active-low write strobe |
| sel_n | input | 3 | Active-low nibble selects; bit 2 high, bit 1 middle, bit 0 low |
| ld_n | input | 1 | Active-low output register load |
| bus_d | input | 4 | Nibble data bus |
| code | output | 12 | Word driving the converter switches |

## Verification
The bench assembles words nibble by nibble in two different orders and watches `code` in the middle of each write. A design that leaked the first rank through to the output would show partial words there. One nibble latch is closed by its select rising while the strobe stays low, and the bus then changes before the strobe rises. A design that captured only on the strobe edge, or that reversed the NOR sense, would load the wrong nibble. The bench also drives every control low with the strobe high, to catch a rank that ignores the strobe qualification. It drives every control low with the strobe low as well, to confirm that the nibble is replicated across the output, and it pulses reset in the middle of a run to confirm that both ranks are cleared.

// File: rtl/nib_dac_front.sv
module nib_dac_front #(
  parameter int NIB_W = 4,
  parameter int NIBS  = 3
) (
  input  logic                  rst_n,
  input  logic                  wr_n,
  input  logic [NIBS-1:0]       sel_n,
  input  logic                  ld_n,
  input  logic [NIB_W-1:0]      bus_d,
  output logic [NIB_W*NIBS-1:0] code
);
  localparam int CODE_W = NIB_W * NIBS;

  logic [CODE_W-1:0] stage;
  logic              load_open;

  for (genvar i = 0; i < NIBS; i++) begin : g_nib
    logic             open_i;
    logic [NIB_W-1:0] q;

    assign open_i = ~(sel_n[i] | wr_n);

    always_latch begin
      if (!rst_n)      q <= '0;
      else if (open_i) q <= bus_d;
    end

    assign stage[i*NIB_W +: NIB_W] = q;
  end

  assign load_open = ~(ld_n | wr_n);

  always_latch begin
    if (!rst_n)         code <= '0;
    else if (load_open) code <= stage;
  end
endmodule

module nib_dac_front_chk #(
  parameter int NIB_W = 4,
  parameter int NIBS  = 3
) (
  input logic                  rst_n,
  input logic                  wr_n,
  input logic [NIBS-1:0]       sel_n,
  input logic                  ld_n,
  input logic [NIB_W-1:0]      bus_d,
  input logic [NIB_W*NIBS-1:0] code,
  input logic [NIB_W*NIBS-1:0] stage
);
  logic                  armed;
  logic [NIB_W*NIBS-1:0] code_at_rise;

  always_ff @(posedge wr_n or negedge rst_n) begin
    if (!rst_n) begin
      armed        <= 1'b0;
      code_at_rise <= '0;
    end else begin
      armed        <= 1'b1;
      code_at_rise <= code;
    end
  end

  a_r1_reset_clear: assert property (@(posedge rst_n) (code == '0) && (stage == '0));

  for (genvar i = 0; i < NIBS; i++) begin : g_a
    a_r2_nib_track: assert property (@(posedge wr_n) disable iff (!rst_n)
      !sel_n[i] |-> stage[i*NIB_W +: NIB_W] == bus_d);
  end

  a_r4_load_track: assert property (@(posedge wr_n) disable iff (!rst_n)
    !ld_n |-> code == stage);

  a_r6_idle_hold: assert property (@(negedge wr_n) disable iff (!rst_n)
    armed |-> code == code_at_rise);
endmodule

bind nib_dac_front nib_dac_front_chk #(.NIB_W(NIB_W), .NIBS(NIBS)) u_chk (.*);

// File: tb/nib_dac_front_bench.sv
module nib_dac_front_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_n;
  logic [2:0]  sel_n;
  logic        ld_n;
  logic [3:0]  bus_d;
  logic [11:0] code;
  int          n_run = 0;
  int          n_fail = 0;
  bit          done = 1'b0;

  always #4 clk = ~clk;

  nib_dac_front u_nib_dac_front (
    .rst_n(rst_n), .wr_n(wr_n), .sel_n(sel_n), .ld_n(ld_n),
    .bus_d(bus_d), .code(code)
  );

  task automatic chk(input string tag, input logic [11:0] exp);
    @(negedge clk);
    n_run++;
    if (code !== exp) begin
      n_fail++;
      $display("FAIL %s actual %h expected %h", tag, code, exp);
    end
  endtask

  task automatic write_nib(input int i, input logic [3:0] v, input logic [11:0] hold_exp);
    @(posedge clk); bus_d = v; sel_n[i] = 1'b0;
    @(posedge clk); wr_n = 1'b0;
    chk("R5 output held during nibble write", hold_exp);
    @(posedge clk); wr_n = 1'b1;
    @(posedge clk); sel_n[i] = 1'b1;
  endtask

  task automatic load_word();
    @(posedge clk); ld_n = 1'b0;
    @(posedge clk); wr_n = 1'b0;
    @(posedge clk); wr_n = 1'b1;
    @(posedge clk); ld_n = 1'b1;
  endtask

  task automatic t_reset();
    chk("R1 reset clears output", 12'h000);
    @(posedge clk); rst_n = 1'b1;
    load_word();
    chk("R1 cleared nibbles after load", 12'h000);
  endtask

  task automatic t_assemble();
    write_nib(2, 4'hA, 12'h000);
    write_nib(1, 4'h5, 12'h000);
    write_nib(0, 4'hC, 12'h000);
    chk("R5 output held after all writes", 12'h000);
    load_word();
    chk("R2 R4 assembled word", 12'hA5C);
    write_nib(0, 4'h1, 12'hA5C);
    write_nib(2, 4'h6, 12'hA5C);
    load_word();
    chk("R2 second order word", 12'h651);
  endtask

  task automatic t_transparent();
    @(posedge clk); bus_d = 4'h7; sel_n = 3'b000; ld_n = 1'b0;
    @(posedge clk); wr_n = 1'b0;
    chk("R7 flow-through 7", 12'h777);
    @(posedge clk); bus_d = 4'hE;
    chk("R7 flow-through E", 12'hEEE);
    @(posedge clk); wr_n = 1'b1;
    @(posedge clk); bus_d = 4'h1;
    chk("R7 R4 hold after strobe release", 12'hEEE);
    @(posedge clk); sel_n = 3'b111; ld_n = 1'b1;
  endtask

  task automatic t_capture();
    @(posedge clk); bus_d = 4'h3; sel_n[1] = 1'b0;
    @(posedge clk); wr_n = 1'b0;
    @(posedge clk); bus_d = 4'h9;
    @(posedge clk); sel_n[1] = 1'b1;
    @(posedge clk); bus_d = 4'h6;
    chk("R5 hold during select release", 12'hEEE);
    @(posedge clk); wr_n = 1'b1;
    load_word();
    chk("R3 capture on select release", 12'hE9E);
    write_nib(0, 4'h5, 12'hE9E);
    @(posedge clk); bus_d = 4'hA;
    load_word();
    chk("R3 capture on strobe release", 12'hE95);
  endtask

  task automatic t_noop();
    @(posedge clk); bus_d = 4'hF; sel_n = 3'b000; ld_n = 1'b0;
    chk("R6 no change with strobe high", 12'hE95);
    @(posedge clk); bus_d = 4'h2;
    chk("R6 no change on bus move", 12'hE95);
    @(posedge clk); sel_n = 3'b111; ld_n = 1'b1;
    load_word();
    chk("R6 nibble latches untouched", 12'hE95);
  endtask

  task automatic t_mid_reset();
    @(posedge clk); rst_n = 1'b0;
    chk("R1 async clear mid run", 12'h000);
    @(posedge clk); rst_n = 1'b1;
    load_word();
    chk("R1 nibbles cleared mid run", 12'h000);
  endtask

  initial begin
    rst_n = 1'b0; wr_n = 1'b1; sel_n = 3'b111; ld_n = 1'b1; bus_d = 4'h0;
    repeat (3) @(posedge clk);
    t_reset();
    t_assemble();
    t_transparent();
    t_capture();
    t_noop();
    t_mid_reset();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog expired before all requirements ran");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule